// File: doc/BRIEF.md
# Multi-Lane Serial Audio Transmitter

This block sends up to eight PCM channels out over four serial data lanes that share one bit clock and one frame clock. The bit clock runs at half the system clock. Each frame takes one word per channel from a wide sample port through a one-cycle ready/valid exchange. Three framings are available: I2S, and two short-pulse formats that differ by one bit of data delay. In I2S the channels are paired across the lanes. In the short-pulse formats every channel is time-multiplexed onto lane 0 in a slot count rounded up to 2, 4 or 8.

Framing, word width, channel count and the two clock polarities are set on plain inputs. They are captured only when the enable input rises. Changing them takes a drop and a re-raise of enable. If a frame boundary arrives with no sample offered, that frame goes out as zeros and a flag is raised. The flag stays high until enable is lowered.

Top module: `tdm_ser`

## Requirements
- R1: After reset, and within one clock of enable going low, all lanes drive 0, the underrun flag is 0 and `smp_ready` stays low. After reset both clocks are 0.
- R2: While enabled, the normalised bit clock (`bclk_o` XOR the captured bit-clock invert) alternates every system clock, so one bit lasts two clocks. Lanes and frame clock change only where the normalised bit clock falls. A receiver samples on its rise.
- R3: With `fmt_sel` 0 (I2S) or 3 (treated as I2S), lane k carries channel 2k in slot 0 and channel 2k+1 in slot 1 of a two-slot frame. Slots whose channel index is not below the channel count are 0. Lanes with no channel are 0.
- R4: With `fmt_sel` 1 or 2, channel s occupies slot s of lane 0, and lanes 1 to 3 are 0. The frame has 2 slots for up to 2 channels, 4 for 3 or 4 channels, and 8 for 5 to 8 channels. Padding slots are 0.
- R5: In I2S, with slot width W and data positions 0 to 2W-1, the normalised frame clock is high exactly at data positions W-1 through 2W-2. Each half of the frame clock is one slot long, and data lags the frame-clock edge by one bit.
- R6: With `fmt_sel` 1 the normalised frame clock is a one-bit pulse on data position 0. With `fmt_sel` 2 it is a one-bit pulse on the last data position, so data follows the pulse by one bit.
- R7: With `w32_sel`=0 a slot is 16 bits and carries bits [15:0] of the channel word, MSB first. With `w32_sel`=1 a slot is 32 bits and carries bits [31:0], MSB first. Channel c is `smp_data[32c+31:32c]`.
- R8: `bck_inv_sel` and `fck_inv_sel` independently invert their clock outputs, in all four combinations. While disabled, each clock rests at the invert value captured at the last enable.
- R9: `smp_ready` is high for exactly one clock per frame, in the clock before the frame's first data bit is driven. The words are taken in that clock.
- R10: If `smp_valid` is low while `smp_ready` is high, that frame is sent as all zeros and `uflow_o` goes high. It stays high while enable stays high.
- R11: Configuration inputs are captured on the clock where enable rises. Changes while enabled have no effect on the output.
- R12: A channel count below 2 acts as 2. A channel count above 8 acts as 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; a rising edge captures the configuration |
| fmt_sel | input | 2 | Framing: 0 I2S, 1 pulse without delay, 2 pulse with one-bit delay, 3 as I2S |
| w32_sel | input | 1 | 0: 16-bit slots, 1: 32-bit slots |
| nch_sel | input | 4 | Channel count (2 to 8, clamped) |
| bck_inv_sel | input | 1 | Invert bit clock |
| fck_inv_sel | input | 1 | Invert frame clock |
| smp_data | input | 256 | Eight 32-bit channel words, channel c at bits 32c+31:32c |
| smp_valid | input | 1 | Sample words are offered |
| smp_ready | output | 1 | Words are taken this clock |
| bclk_o | output | 1 | Bit clock |
| fclk_o | output | 1 | Frame clock |
| sd_o | output | 4 | Serial data lanes |
| uflow_o | output | 1 | Sticky underrun flag |

## Verification
Two things happen in the same clock at the end of every frame. The last bit of the frame is still being framed, and that last bit carries the delayed-format frame pulse. In that same clock the next frame's words are fetched, or an underrun is declared. The bench provokes this boundary by sweeping every framing, both widths and channel counts 1 to 9, withholding a frame in every third run. It also rewrites all configuration inputs during each run. Each lane is deserialised from the normalised bit clock, and every frame-clock level, recovered word, zero frame and flag is judged against the configuration saved at enable.

// File: rtl/tdm_ser_pkg.sv
package tdm_ser_pkg;
  typedef enum logic [1:0] {
    FMT_I2S   = 2'd0,
    FMT_DSP_A = 2'd1,
    FMT_DSP_B = 2'd2,
    FMT_RSVD  = 2'd3
  } fmt_e;

  typedef struct packed {
    fmt_e       fmt;
    logic       w32;
    logic [3:0] nch;
    logic       bck_inv;
    logic       fck_inv;
  } cfg_t;
endpackage

// File: rtl/tdm_ser_cfg.sv
module tdm_ser_cfg
  import tdm_ser_pkg::*;
#(
  parameter int MAXCH = 8,
  parameter int CW    = 32,
  parameter int PW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  cfg_t          cfg_in,
  output cfg_t          cfg_d,
  output logic          is_i2s,
  output logic [PW-1:0] slot_last,
  output logic [PW-1:0] frame_last
);
  localparam int SH_W = $clog2(CW);

  cfg_t       cfg_q;
  cfg_t       cfg_s;
  logic [PW:0] slots;
  logic [PW:0] fbits;

  // clamp the channel count before capture
  always_comb begin
    cfg_s = cfg_in;
    if (cfg_in.nch < 4'd2)              cfg_s.nch = 4'd2;
    else if (cfg_in.nch > 4'(MAXCH))    cfg_s.nch = 4'(MAXCH);
  end

  // the capture edge already uses the new settings
  assign cfg_d = start ? cfg_s : cfg_q;

  always_comb begin
    is_i2s = !((cfg_d.fmt == FMT_DSP_A) || (cfg_d.fmt == FMT_DSP_B));
    if (is_i2s || cfg_d.nch <= 4'd2) slots = (PW+1)'(2);
    else if (cfg_d.nch <= 4'd4)      slots = (PW+1)'(4);
    else                             slots = (PW+1)'(8);
    fbits      = cfg_d.w32 ? (slots << SH_W) : (slots << (SH_W - 1));
    frame_last = PW'(fbits - 1'b1);
    slot_last  = cfg_d.w32 ? PW'(CW - 1) : PW'(CW/2 - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= '0;
    else if (start) cfg_q <= cfg_s;
  end
endmodule

// File: rtl/tdm_ser_timer.sv
module tdm_ser_timer #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [PW-1:0] frame_last,
  output logic          run_q,
  output logic          start,
  output logic          adv,
  output logic          wrap,
  output logic          ph_n,
  output logic [PW-1:0] pos_n
);
  logic          ph_q;
  logic [PW-1:0] pos_q;

  always_comb begin
    start = en & ~run_q;
    adv   = en & run_q & ph_q;
    wrap  = adv & (pos_q == frame_last);
    ph_n  = en & run_q & ~ph_q;
    if (start)     pos_n = frame_last;
    else if (wrap) pos_n = '0;
    else if (adv)  pos_n = pos_q + 1'b1;
    else           pos_n = pos_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ph_q  <= 1'b0;
      pos_q <= '0;
    end else begin
      run_q <= en;
      ph_q  <= ph_n;
      pos_q <= pos_n;
    end
  end
endmodule

// File: rtl/tdm_ser_lanes.sv
module tdm_ser_lanes #(
  parameter int NLANE = 4,
  parameter int MAXCH = 8,
  parameter int CW    = 32,
  parameter int PW    = 8
) (
  input  logic                  is_i2s,
  input  logic                  dsp_late,
  input  logic                  w32,
  input  logic [3:0]            nch,
  input  logic                  fck_inv,
  input  logic [PW-1:0]         slot_last,
  input  logic [PW-1:0]         frame_last,
  input  logic [PW-1:0]         pos,
  input  logic [MAXCH*CW-1:0]   words,
  output logic [NLANE-1:0]      sd,
  output logic                  fsync
);
  localparam int SH_W = $clog2(CW);
  localparam int CHW  = $clog2(MAXCH);

  logic [CW-1:0]   wa [MAXCH];
  logic [PW-1:0]   slot;
  logic [SH_W-1:0] bidx;
  logic            fs_raw;

  always_comb begin
    for (int c = 0; c < MAXCH; c++) wa[c] = words[c*CW +: CW];
    slot = w32 ? (pos >> SH_W) : (pos >> (SH_W - 1));
    bidx = SH_W'(slot_last - (pos & slot_last));
  end

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    logic [PW-1:0] ch;
    logic          hit;
    always_comb begin
      ch    = is_i2s ? (PW'(2*l) + slot) : slot;
      hit   = (is_i2s || (l == 0)) && (ch < PW'(nch));
      sd[l] = hit ? wa[ch[CHW-1:0]][bidx] : 1'b0;
    end
  end

  always_comb begin
    if (is_i2s)        fs_raw = (pos >= slot_last) && (pos <= (slot_last << 1));
    else if (dsp_late) fs_raw = (pos == frame_last);
    else               fs_raw = (pos == '0);
    fsync = fs_raw ^ fck_inv;
  end
endmodule

// File: rtl/tdm_ser.sv
module tdm_ser
  import tdm_ser_pkg::*;
#(
  parameter int NLANE = 4,
  parameter int MAXCH = 8,
  parameter int CW    = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic [1:0]            fmt_sel,
  input  logic                  w32_sel,
  input  logic [3:0]            nch_sel,
  input  logic                  bck_inv_sel,
  input  logic                  fck_inv_sel,
  input  logic [MAXCH*CW-1:0]   smp_data,
  input  logic                  smp_valid,
  output logic                  smp_ready,
  output logic                  bclk_o,
  output logic                  fclk_o,
  output logic [NLANE-1:0]      sd_o,
  output logic                  uflow_o
);
  localparam int PW = $clog2(MAXCH*CW);

  cfg_t                cfg_in;
  cfg_t                cfg_d;
  logic                is_i2s;
  logic [PW-1:0]       slot_last;
  logic [PW-1:0]       frame_last;
  logic                run_q, start, adv, wrap, ph_n;
  logic [PW-1:0]       pos_n;
  logic [MAXCH*CW-1:0] words_q, words_n;
  logic [NLANE-1:0]    lane_sd, sd_n;
  logic                lane_fs, fclk_n, bclk_n, uflow_n;
  logic                load_out, words_en;
  logic                binv_cur, dsp_cur;

  always_comb begin
    cfg_in.fmt     = fmt_e'(fmt_sel);
    cfg_in.w32     = w32_sel;
    cfg_in.nch     = nch_sel;
    cfg_in.bck_inv = bck_inv_sel;
    cfg_in.fck_inv = fck_inv_sel;
  end

  tdm_ser_cfg #(.MAXCH(MAXCH), .CW(CW), .PW(PW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_in(cfg_in),
    .cfg_d(cfg_d), .is_i2s(is_i2s), .slot_last(slot_last), .frame_last(frame_last)
  );

  tdm_ser_timer #(.PW(PW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .en(en), .frame_last(frame_last),
    .run_q(run_q), .start(start), .adv(adv), .wrap(wrap), .ph_n(ph_n), .pos_n(pos_n)
  );

  tdm_ser_lanes #(.NLANE(NLANE), .MAXCH(MAXCH), .CW(CW), .PW(PW)) u_lanes (
    .is_i2s(is_i2s), .dsp_late(cfg_d.fmt == FMT_DSP_B), .w32(cfg_d.w32),
    .nch(cfg_d.nch), .fck_inv(cfg_d.fck_inv), .slot_last(slot_last),
    .frame_last(frame_last), .pos(pos_n), .words(words_n),
    .sd(lane_sd), .fsync(lane_fs)
  );

  assign smp_ready = wrap;
  assign binv_cur  = cfg_d.bck_inv;
  assign dsp_cur   = ~is_i2s;

  // next-state logic
  always_comb begin
    words_en = start | wrap;
    if (start)          words_n = '0;
    else if (wrap)      words_n = smp_valid ? smp_data : '0;
    else                words_n = words_q;
    load_out = start | adv;
    if (!en)            sd_n = '0;
    else if (load_out)  sd_n = lane_sd;
    else                sd_n = sd_o;
    if (!en)            fclk_n = cfg_d.fck_inv;
    else if (load_out)  fclk_n = lane_fs;
    else                fclk_n = fclk_o;
    bclk_n = ph_n ^ cfg_d.bck_inv;
    if (!en)                     uflow_n = 1'b0;
    else if (wrap && !smp_valid) uflow_n = 1'b1;
    else                         uflow_n = uflow_o;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words_q <= '0;
      sd_o    <= '0;
      fclk_o  <= 1'b0;
      bclk_o  <= 1'b0;
      uflow_o <= 1'b0;
    end else begin
      if (words_en) words_q <= words_n;
      sd_o    <= sd_n;
      fclk_o  <= fclk_n;
      bclk_o  <= bclk_n;
      uflow_o <= uflow_n;
    end
  end
endmodule

// File: rtl/tdm_ser_chk.sv
module tdm_ser_chk #(
  parameter int NLANE = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             smp_valid,
  input logic             smp_ready,
  input logic             bclk_o,
  input logic             fclk_o,
  input logic [NLANE-1:0] sd_o,
  input logic             uflow_o,
  input logic             run_q,
  input logic             binv_cur,
  input logic             dsp_cur
);
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (sd_o == '0) && !uflow_o && !smp_ready);

  p_edge_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((sd_o != $past(sd_o)) || (fclk_o != $past(fclk_o))) && $past(en) |-> !(bclk_o ^ binv_cur));

  p_dsp_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && dsp_cur |-> (sd_o[NLANE-1:1] == '0));

  p_ready_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready |=> !smp_ready);

  p_uflow_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready && !smp_valid |=> uflow_o);

  p_uflow_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    uflow_o && en |=> uflow_o);
endmodule

bind tdm_ser tdm_ser_chk #(.NLANE(NLANE)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .smp_valid(smp_valid), .smp_ready(smp_ready),
  .bclk_o(bclk_o), .fclk_o(fclk_o), .sd_o(sd_o), .uflow_o(uflow_o),
  .run_q(run_q), .binv_cur(binv_cur), .dsp_cur(dsp_cur)
);

// File: tb/sim_tdm_ser.sv
module sim_tdm_ser;
  localparam int NLANE = 4;
  localparam int MAXCH = 8;
  localparam int CW    = 32;
  localparam int RUN_LIMIT = 1800;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                rst_n, en, w32_sel, bck_inv_sel, fck_inv_sel, smp_valid;
  logic [1:0]          fmt_sel;
  logic [3:0]          nch_sel;
  logic [MAXCH*CW-1:0] smp_data;
  logic                smp_ready, bclk_o, fclk_o, uflow_o;
  logic [NLANE-1:0]    sd_o;

  tdm_ser u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .fmt_sel(fmt_sel), .w32_sel(w32_sel),
    .nch_sel(nch_sel), .bck_inv_sel(bck_inv_sel), .fck_inv_sel(fck_inv_sel),
    .smp_data(smp_data), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .bclk_o(bclk_o), .fclk_o(fclk_o), .sd_o(sd_o), .uflow_o(uflow_o)
  );

  int checks = 0;
  int errors = 0;

  // saved configuration of the current run
  int s_fmt, s_nch, s_nraw, SW, FB, nslots, run_idx;
  bit s_i2s, s_w32, s_binv, s_finv, ur_run;
  // receiver and driver state
  bit rx_on, first, started, prev_bn, have_edge, period_bad, frame_bad;
  bit prev_ready, ready_bad, upd_pending;
  int bp, nrx, nsent;
  longint cyc, last_edge;
  logic [31:0] sent [8][8];
  bit          under [8];
  logic [31:0] rx [NLANE][8];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(int r, int f, int ch);
    int v;
    v = (r*64 + f*8 + ch + 1) * 32'h9E3779B1;
    return 32'(v) ^ 32'h5A5A1234;
  endfunction

  function automatic bit exp_fs(int p);
    if (s_i2s)           return (p >= SW-1) && (p <= 2*SW-2);
    else if (s_fmt == 1) return p == 0;
    else                 return p == FB-1;
  endfunction

  task automatic set_data(input int f);
    for (int ch = 0; ch < MAXCH; ch++) smp_data[ch*CW +: CW] = word_of(run_idx, f, ch);
    smp_valid = !(ur_run && f == 1);
  endtask

  task automatic finish_frame();
    int f;
    f = nrx;
    for (int l = 0; l < NLANE; l++) begin
      for (int s = 0; s < nslots; s++) begin
        int ch;
        logic [31:0] e;
        string tag;
        ch = s_i2s ? 2*l + s : ((l == 0) ? s : -1);
        if (ch >= 0 && ch < s_nch && f < nsent)
          e = s_w32 ? sent[f][ch] : {16'h0, sent[f][ch][15:0]};
        else
          e = 32'h0;
        if (s_nraw < 2 || s_nraw > 8) tag = "R12";
        else if (under[f])            tag = "R10";
        else if (!s_w32)              tag = "R7";
        else if (s_i2s)               tag = "R3";
        else                          tag = "R4";
        chk(rx[l][s] == e, tag, $sformatf("run %0d frame %0d lane %0d slot %0d", run_idx, f, l, s),
            longint'(rx[l][s]), longint'(e));
      end
    end
    nrx++;
  endtask

  task automatic step();
    bit bn, fn;
    @(posedge clk);
    #2;
    cyc++;
    if (upd_pending) begin
      set_data(nsent);
      upd_pending = 0;
    end
    if (rx_on) begin
      if (smp_ready) begin
        if (prev_ready) ready_bad = 1;
        if (nsent < 8) begin
          for (int ch = 0; ch < MAXCH; ch++) sent[nsent][ch] = smp_valid ? smp_data[ch*CW +: CW] : 32'h0;
          under[nsent] = !smp_valid;
          nsent++;
        end
        upd_pending = 1;
      end
      prev_ready = smp_ready;
      bn = bclk_o ^ s_binv;
      fn = fclk_o ^ s_finv;
      if (!prev_bn && bn) begin
        if (have_edge && (cyc - last_edge) != 2) period_bad = 1;
        last_edge = cyc;
        have_edge = 1;
        if (first) begin bp = FB-1; first = 0; end
        else bp = (bp == FB-1) ? 0 : bp + 1;
        if (fn != exp_fs(bp)) frame_bad = 1;
        if (bp == 0) begin
          started = 1;
          for (int l = 0; l < NLANE; l++) for (int s = 0; s < 8; s++) rx[l][s] = 32'h0;
        end
        for (int l = 0; l < NLANE; l++) rx[l][bp/SW] = {rx[l][bp/SW][30:0], sd_o[l]};
        if (bp == FB-1 && started) finish_frame();
      end
      prev_bn = bn;
    end
  endtask

  task automatic run_cfg(input int fmt, input int w, input int n);
    int combo, k;
    run_idx++;
    combo  = (n + fmt + w) % 4;
    s_fmt  = fmt;
    s_i2s  = (fmt == 0 || fmt == 3);
    s_w32  = (w == 1);
    s_nraw = n;
    s_nch  = (n < 2) ? 2 : ((n > 8) ? 8 : n);
    s_binv = combo[0];
    s_finv = combo[1];
    SW     = s_w32 ? 32 : 16;
    nslots = s_i2s ? 2 : ((s_nch <= 2) ? 2 : ((s_nch <= 4) ? 4 : 8));
    FB     = nslots * SW;
    ur_run = (run_idx % 3 == 1);
    fmt_sel = 2'(fmt); w32_sel = s_w32; nch_sel = 4'(n);
    bck_inv_sel = s_binv; fck_inv_sel = s_finv;
    nsent = 0; nrx = 0; first = 1; started = 0; prev_bn = 0; have_edge = 0;
    period_bad = 0; frame_bad = 0; prev_ready = 0; ready_bad = 0; upd_pending = 0;
    for (int i = 0; i < 8; i++) under[i] = 0;
    set_data(0);
    step(); step();
    en = 1; rx_on = 1;
    k = 0;
    while (nrx < 3 && k < RUN_LIMIT) begin
      step();
      k++;
      if (k == 5) begin
        // R11: rewrite every setting while running
        fmt_sel = 2'(fmt + 1); w32_sel = !s_w32; nch_sel = 4'(10 - n);
        bck_inv_sel = !s_binv; fck_inv_sel = !s_finv;
      end
    end
    chk(k < RUN_LIMIT, "R11", "watchdog expired waiting for frames", k, RUN_LIMIT);
    chk(nrx == 3, "R11", "frames recovered with captured settings", nrx, 3);
    chk(!period_bad, "R2", "bit period of two clocks", period_bad, 0);
    chk(!frame_bad, s_i2s ? "R5" : "R6", "frame clock position", frame_bad, 0);
    chk(!ready_bad && nsent >= 3, "R9", "ready single pulse per frame", nsent, 3);
    chk(uflow_o == ur_run, "R10", "underrun flag at end of run", uflow_o, ur_run);
    en = 0; rx_on = 0;
    step(); step();
    chk(sd_o == '0, "R1", "lanes idle after disable", sd_o, 0);
    chk(uflow_o == 1'b0, "R1", "flag cleared after disable", uflow_o, 0);
    chk(bclk_o == s_binv, "R8", "bit clock rest level", bclk_o, s_binv);
    chk(fclk_o == s_finv, "R8", "frame clock rest level", fclk_o, s_finv);
  endtask

  initial begin
    rst_n = 0; en = 0; fmt_sel = 0; w32_sel = 0; nch_sel = 0;
    bck_inv_sel = 0; fck_inv_sel = 0; smp_data = '0; smp_valid = 0;
    rx_on = 0; cyc = 0; run_idx = 0;
    step(); step(); step();
    rst_n = 1;
    step();
    chk({sd_o, bclk_o, fclk_o, uflow_o, smp_ready} == '0, "R1", "reset state",
        {sd_o, bclk_o, fclk_o, uflow_o, smp_ready}, 0);
    for (int fmt = 0; fmt < 4; fmt++)
      for (int w = 0; w < 2; w++)
        for (int n = 1; n <= 9; n++)
          run_cfg(fmt, w, n);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule